// File: doc/BRIEF.md
# Multi-camera pixel packer with round-robin arbitration

This block collects 8-bit pixel streams from several cameras and merges them into one stream of 32-bit words for a downstream FIFO that writes to memory. Each camera feeds a small queue of its own. When a queue holds at least three pixels, the camera becomes a candidate for the output slot. A round-robin arbiter hands the slot to one candidate at a time. The granted camera gives up exactly three pixels, which are packed into one word with a header byte. The header names the camera and carries a per-camera packet sequence number.

The output is a registered valid/ready port. A word stays in place until the downstream side takes it, and the block can load a new word on every cycle while the slot is free. A frame-start pulse restarts the sequence numbers. Each camera also has a sticky flag that reports a pixel dropped because its queue was full. The packing path handles one word per clock, so two cameras at roughly 33 Mpixel/s each leave ample headroom at any core clock above the combined pixel rate.

Top module: `cam_pack_arbiter`

## Requirements
- R1: Each camera has a queue of FIFO_DEPTH pixels. A pixel presented with its valid bit while the queue holds fewer than FIFO_DEPTH pixels is stored, and pixels leave the queue in arrival order.
- R2: An output word holds three pixels of one camera, with the oldest in bits [7:0], the next in [15:8] and the third in [23:16]. Bits [31:24] hold the header.
- R3: Header bits [31:30] carry the camera index (0 to NUM_CAMS-1, up to 4 cameras). Bits [29:24] carry that camera's packet count, which starts at 0 and increments by one per packet, modulo 64.
- R4: A frame_start pulse clears every camera's packet count. A packet loaded in the same cycle carries count 0, and that camera's next packet carries 1.
- R5: A camera is a candidate only while its queue holds three or more pixels. Cameras with fewer are skipped, and no word is produced from a partial packet.
- R6: After camera c is granted, the next search starts at camera (c+1) mod NUM_CAMS and picks the first candidate in increasing index order, wrapping around.
- R7: While out_valid is 1 and out_ready is 0, out_data stays unchanged, out_valid stays 1, and no pixels are removed from any queue.
- R8: A pixel presented while its camera's queue is full is dropped and sets that camera's overflow bit. The bit stays set until rst_n is asserted.
- R9: When the slot is empty or being accepted, a word is loaded at the same edge at which a candidate exists. A camera whose third pixel is written at edge t can be granted at edge t+1, and the block can load one word on every cycle.
- R10: While rst_n is low, out_valid, out_data and overflow are zero, the queues are empty, the packet counts are zero and the search starts at camera 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Restarts all packet counts |
| pix_valid | input | NUM_CAMS | Per-camera pixel strobe |
| pix_data | input | 8*NUM_CAMS | Per-camera pixel, camera c in bits [8c+7:8c] |
| out_ready | input | 1 | Downstream FIFO can take a word |
| out_valid | output | 1 | out_data holds a packed word |
| out_data | output | 32 | Header byte and three pixels |
| overflow | output | NUM_CAMS | Sticky per-camera drop flag |

## Verification
A pixel sampled at edge t is counted in its queue from t+1. A grant made at an edge is visible on out_valid and out_data right after that edge, so the earliest word for three fresh pixels appears one edge after the third pixel. An overflow bit becomes visible just after the edge that sampled the dropped pixel. The bench's reference model applies those same edge-by-edge updates from the requirements, and every output is compared at the falling edge that follows, where all of them have settled. The directed checks wait for out_valid and do not count fixed delays, so they do not depend on the exact pipeline depth.

// File: rtl/cam_pack_arbiter.sv
module cam_pack_arbiter #(
  parameter int NUM_CAMS   = 2,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [NUM_CAMS-1:0]   pix_valid,
  input  logic [NUM_CAMS*8-1:0] pix_data,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [31:0]           out_data,
  output logic [NUM_CAMS-1:0]   overflow
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int IW = (NUM_CAMS > 1) ? $clog2(NUM_CAMS) : 1;
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);

  logic [7:0]    mem    [NUM_CAMS][FIFO_DEPTH];
  logic [AW-1:0] wr_ptr [NUM_CAMS];
  logic [AW-1:0] rd_ptr [NUM_CAMS];
  logic [CW-1:0] cnt    [NUM_CAMS];
  logic [5:0]    seq    [NUM_CAMS];
  logic [IW-1:0] rr_ptr;

  logic [NUM_CAMS-1:0]    eligible, accept, pop;
  logic                   grant_any, take;
  logic [IW-1:0]          grant_idx;
  logic [AW-1:0]          rp;
  logic [5:0]             hdr_seq;
  logic [CW*NUM_CAMS-1:0] cnt_flat;

  assign take    = grant_any && (!out_valid || out_ready);
  assign rp      = rd_ptr[grant_idx];
  assign hdr_seq = frame_start ? 6'd0 : seq[grant_idx];

  for (genvar c = 0; c < NUM_CAMS; c++) begin : g_cam
    assign eligible[c]            = cnt[c] >= CW'(3);
    assign accept[c]              = pix_valid[c] && (cnt[c] != FULL);
    assign pop[c]                 = take && (grant_idx == IW'(c));
    assign cnt_flat[c*CW +: CW]   = cnt[c];
  end

  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < NUM_CAMS; k++) begin
      if (!grant_any && eligible[(int'(rr_ptr) + k) % NUM_CAMS]) begin
        grant_any = 1'b1;
        grant_idx = IW'((int'(rr_ptr) + k) % NUM_CAMS);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CAMS; c++)
      if (accept[c]) mem[c][wr_ptr[c]] <= pix_data[c*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CAMS; c++) begin
        wr_ptr[c] <= '0;
        rd_ptr[c] <= '0;
        cnt[c]    <= '0;
        seq[c]    <= '0;
      end
      overflow <= '0;
    end else begin
      for (int c = 0; c < NUM_CAMS; c++) begin
        cnt[c]    <= cnt[c] + CW'(accept[c]) - (pop[c] ? CW'(3) : CW'(0));
        wr_ptr[c] <= wr_ptr[c] + AW'(accept[c]);
        rd_ptr[c] <= rd_ptr[c] + (pop[c] ? AW'(3) : AW'(0));
        if (pix_valid[c] && (cnt[c] == FULL)) overflow[c] <= 1'b1;
        if (frame_start)  seq[c] <= pop[c] ? 6'd1 : 6'd0;
        else if (pop[c])  seq[c] <= seq[c] + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      rr_ptr    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= {2'(grant_idx), hdr_seq,
                    mem[grant_idx][rp + AW'(2)],
                    mem[grant_idx][rp + AW'(1)],
                    mem[grant_idx][rp]};
      rr_ptr    <= (grant_idx == IW'(NUM_CAMS - 1)) ? '0 : grant_idx + IW'(1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_pack_arbiter_chk.sv
module cam_pack_arbiter_chk #(
  parameter int NUM_CAMS   = 2,
  parameter int FIFO_DEPTH = 8
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   out_valid,
  input logic                                   out_ready,
  input logic [31:0]                            out_data,
  input logic [NUM_CAMS-1:0]                    overflow,
  input logic [$clog2(FIFO_DEPTH+1)*NUM_CAMS-1:0] cnt_flat
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_drop_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  a_r3_cam_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_data[31:30]) < NUM_CAMS));

  for (genvar c = 0; c < NUM_CAMS; c++) begin : g_chk
    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[c] |=> overflow[c]);
    a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_flat[c*CW +: CW]) <= FIFO_DEPTH);
  end
endmodule

bind cam_pack_arbiter cam_pack_arbiter_chk #(
  .NUM_CAMS(NUM_CAMS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .cnt_flat(cnt_flat)
);

// File: tb/tb_cam_pack_arbiter.sv
module tb_cam_pack_arbiter;
  localparam int N = 3;
  localparam int D = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [N-1:0]  pix_valid = '0;
  logic [N*8-1:0] pix_data = '0;
  logic          out_ready = 1'b1;
  logic          out_valid;
  logic [31:0]   out_data;
  logic [N-1:0]  overflow;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #10 clk = ~clk;

  cam_pack_arbiter #(.NUM_CAMS(N), .FIFO_DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_data(pix_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow));

  logic [7:0]  q [N][$];
  int          mseq [N];
  int          mrr;
  bit          mvalid;
  logic [31:0] mdata;
  logic [N-1:0] movf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin q[c].delete(); mseq[c] = 0; end
      mrr = 0; mvalid = 0; mdata = '0; movf = '0;
    end else begin
      int g;
      int pre [N];
      bit free;
      g = -1;
      free = !mvalid || out_ready;
      for (int c = 0; c < N; c++) pre[c] = q[c].size();
      for (int k = 0; k < N; k++)
        if (g < 0 && pre[(mrr + k) % N] >= 3) g = (mrr + k) % N;
      if (free && g >= 0) begin
        logic [7:0] p0, p1, p2;
        int hs;
        hs = frame_start ? 0 : mseq[g];
        p0 = q[g].pop_front(); p1 = q[g].pop_front(); p2 = q[g].pop_front();
        mdata = {2'(g), 6'(hs), p2, p1, p0};
        mvalid = 1;
        mseq[g] = (hs + 1) % 64;
        mrr = (g + 1) % N;
      end else if (out_ready) begin
        mvalid = 0;
      end
      if (frame_start)
        for (int c = 0; c < N; c++) if (!(free && g == c)) mseq[c] = 0;
      for (int c = 0; c < N; c++)
        if (pix_valid[c]) begin
          if (pre[c] < D) q[c].push_back(pix_data[c*8 +: 8]);
          else movf[c] = 1'b1;
        end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R9 R5 out_valid vs model", 32'(out_valid), 32'(mvalid));
      if (mvalid) chk("R1 R2 R3 R4 R6 out_data vs model", out_data, mdata);
      chk("R8 overflow vs model", 32'(overflow), 32'(movf));
    end
  end

  task automatic push(input logic [N-1:0] v, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c2);
    pix_valid = v;
    pix_data = {c2, b, a};
    @(negedge clk);
    pix_valid = '0;
  endtask

  task automatic wait_valid(input string tag);
    int n;
    n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    if (!out_valid) chk(tag, 32'(out_valid), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int order [3];
    int got;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R10 overflow in reset", 32'(overflow), 32'd0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);

    // R2: three pixels of camera 0 in order
    push(3'b001, 8'h11, 8'h00, 8'h00);
    push(3'b001, 8'h22, 8'h00, 8'h00);
    push(3'b001, 8'h33, 8'h00, 8'h00);
    wait_valid("R2 word never appeared");
    chk("R2 packed layout", out_data, 32'h00332211);
    @(negedge clk);

    // R3: camera 2 header, then camera 0 second packet
    push(3'b100, 8'h00, 8'h00, 8'h44);
    push(3'b100, 8'h00, 8'h00, 8'h55);
    push(3'b100, 8'h00, 8'h00, 8'h66);
    wait_valid("R3 word never appeared");
    chk("R3 camera id 2", out_data, 32'h80665544);
    @(negedge clk);
    push(3'b001, 8'hA1, 8'h00, 8'h00);
    push(3'b001, 8'hA2, 8'h00, 8'h00);
    push(3'b001, 8'hA3, 8'h00, 8'h00);
    wait_valid("R3 word never appeared");
    chk("R3 sequence increments", out_data, 32'h01A3A2A1);
    @(negedge clk);

    // R5: two pixels are not enough
    push(3'b010, 8'h00, 8'h77, 8'h00);
    push(3'b010, 8'h00, 8'h78, 8'h00);
    repeat (6) @(negedge clk);
    chk("R5 partial packet held back", 32'(out_valid), 32'd0);

    // R4: frame start restarts the count
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    push(3'b001, 8'hB1, 8'h00, 8'h00);
    push(3'b001, 8'hB2, 8'h00, 8'h00);
    push(3'b001, 8'hB3, 8'h00, 8'h00);
    wait_valid("R4 word never appeared");
    chk("R4 count restarted", out_data, 32'h00B3B2B1);
    @(negedge clk);

    // R6 and R7: stall, fill all cameras, then drain
    out_ready = 1'b0;
    push(3'b111, 8'hC1, 8'hD1, 8'hE1);
    push(3'b111, 8'hC2, 8'hD2, 8'hE2);
    push(3'b111, 8'hC3, 8'hD3, 8'hE3);
    wait_valid("R7 word never appeared");
    held = out_data;
    repeat (4) @(negedge clk);
    chk("R7 valid held under stall", 32'(out_valid), 32'd1);
    chk("R7 data held under stall", out_data, held);
    out_ready = 1'b1;
    got = 0;
    for (int i = 0; i < 20 && got < 3; i++) begin
      if (out_valid) begin order[got] = int'(out_data[31:30]); got++; end
      @(negedge clk);
    end
    chk("R6 first grant", 32'(order[0]), 32'd1);
    chk("R6 second grant", 32'(order[1]), 32'd2);
    chk("R6 third grant", 32'(order[2]), 32'd0);
    repeat (4) @(negedge clk);

    // R8: overflow camera 1 under stall
    out_ready = 1'b0;
    for (int i = 0; i < 20; i++) push(3'b010, 8'h00, 8'(i), 8'h00);
    chk("R8 overflow set", 32'(overflow[1]), 32'd1);
    out_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 overflow sticky", 32'(overflow[1]), 32'd1);

    // R9: all cameras streaming, one word per cycle keeps up
    for (int i = 0; i < 60; i++) push(3'b111, 8'(i), 8'(i + 64), 8'(i + 128));
    repeat (6) @(negedge clk);
    chk("R9 no loss on camera 0", 32'(overflow[0]), 32'd0);
    chk("R9 no loss on camera 2", 32'(overflow[2]), 32'd0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      pix_valid = N'($urandom_range(0, 7)) & N'($urandom_range(0, 7));
      pix_data = N*8'($urandom);
      out_ready = ($urandom_range(0, 3) != 0);
      frame_start = ($urandom_range(0, 49) == 0);
      @(negedge clk);
    end
    pix_valid = '0; frame_start = 1'b0; out_ready = 1'b1;
    repeat (20) @(negedge clk);

    // R10: reset clears flags and output
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 overflow cleared by reset", 32'(overflow), 32'd0);
    chk("R10 out_valid cleared by reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    push(3'b100, 8'h00, 8'h00, 8'hF1);
    push(3'b100, 8'h00, 8'h00, 8'hF2);
    push(3'b100, 8'h00, 8'h00, 8'hF3);
    wait_valid("R10 word never appeared");
    chk("R10 queues and counts restart", out_data, 32'h80F3F2F1);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule